// File: doc/BRIEF.md
# Disk Sector Stream Formatter and Checker

This block builds the serial bit stream of one disk sector for writing and takes apart the same stream on reading. A sector on the medium is laid out as a run of zero bits closed by a single one bit that marks where the fields begin. A header word follows it, then the data words, a checksum word and one trailing word of zeros. All words are sent most significant bit first. For a write, the host first delivers the data words over a ready/valid handshake into an internal buffer. The next sector pulse then starts the stream, one bit per clock.

For a read, the block is armed at a sector pulse. It skips bits until the first one bit, then collects the header and compares it with the expected cylinder and the current sector number. It hands each data word to the host, and finally compares the received checksum with the sum of the received data.

The block also keeps the number of the sector passing under the head. The number advances on every sector pulse. An index pulse tells the block that the current sector is the last one on the track, so the next sector pulse returns the number to 0.

Top module: `sector_fmt`

## Requirements
- R1: `sec_num` is 0 after reset. Each cycle with `sector_pulse` high advances it by one, from 11 back to 0. Without a pulse it holds its value.
- R2: If `index_pulse` was high in any cycle since the previous sector pulse, the next sector pulse sets `sec_num` to 0 instead of advancing it.
- R3: `wr_ready` is high after reset and stays high until 256 words have been accepted (`wr_valid` and `wr_ready` both high at a clock edge). It then stays low until the sector stream that carries those words has ended.
- R4: With all 256 words held, the first sector pulse starts a stream. `tx_en` is high for exactly 4384 consecutive cycles, beginning in the second cycle after the cycle that holds the pulse. Sector pulses seen while words are still loading or while a stream runs do not start a stream.
- R5: The stream on `tx_bit` is, in order: 239 zero bits, one 1 bit, the header word, the 256 data words in their order of acceptance, the checksum word and 16 zero bits. Words are sent MSB first. The header word has `hdr_cyl` in bits 15:4 and, in bits 3:0, the sector number that the starting pulse produces.
- R6: The checksum word is the sum, modulo 2^16, of the 256 data words.
- R7: A sector pulse with `rd_enable` high arms an idle reader. The reader ignores bits until the first 1 bit with `rx_valid` high. The next 16 valid bits are the header. Every further 16 valid bits form a data word, up to 256 words. Each word appears on `rd_word` with `rd_valid` high for one cycle, in the cycle after the clock edge that takes its last bit.
- R8: After the 256 data words, the next 16 valid bits are the received checksum. In the cycle after the edge that takes its last bit, `rd_done` is high for one cycle and `sum_err` shows whether the checksum differs from the modulo 2^16 sum of the received words.
- R9: When `rd_done` is high, `hdr_err` shows whether the received header differs from {`exp_cyl` in bits 15:4, the sector number produced by the arming pulse in bits 3:0}. Both flags hold until the next `rd_done`.
- R10: While `rx_valid` is low, the reader ignores `rx_bit`. A 1 on `rx_bit` at that time is not taken as the sync bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sector_pulse | input | 1 | One-cycle pulse at the start of every sector |
| index_pulse | input | 1 | One-cycle pulse during the last sector of the track |
| sec_num | output | 4 | Number of the current sector |
| wr_valid | input | 1 | Write data word is valid |
| wr_ready | output | 1 | Buffer accepts a write data word |
| wr_data | input | 16 | Write data word |
| hdr_cyl | input | 12 | Cylinder written into the header |
| tx_bit | output | 1 | Serial write stream |
| tx_en | output | 1 | High while `tx_bit` carries the stream |
| rd_enable | input | 1 | Lets a sector pulse arm the reader |
| exp_cyl | input | 12 | Cylinder expected in the read header |
| rx_bit | input | 1 | Serial read stream |
| rx_valid | input | 1 | `rx_bit` carries a bit in this cycle |
| rd_word | output | 16 | Received data word |
| rd_valid | output | 1 | `rd_word` is new in this cycle |
| rd_done | output | 1 | One-cycle pulse when the read sector ends |
| hdr_err | output | 1 | Header of the last read sector did not match |
| sum_err | output | 1 | Checksum of the last read sector did not match |

## Verification
`sec_num` and `wr_ready` change one cycle after the clock edge that samples the pulse or the last accepted word. The first stream bit appears two edges after the starting pulse. `rd_word` and `rd_done` appear one edge after the bit that completes them. The bench drives inputs just after each rising edge. A behavioural model samples those inputs on the same rising edge and works out the expected outputs for the following cycle. On the falling edge, every output is compared with the model. The read side is fed from the write stream by loopback, with the option of flipping a bit or masking one cycle. The model works from the bits the reader actually receives, so the error flags it predicts follow from the stimulus.

// File: rtl/secfmt_pkg.sv
package secfmt_pkg;
  typedef enum logic [1:0] {W_LOAD, W_ARMED, W_SEND} wr_state_e;
  typedef enum logic [2:0] {R_IDLE, R_HUNT, R_HDR, R_DATA, R_SUM} rd_state_e;
endpackage

// File: rtl/secfmt_counter.sv
module secfmt_counter #(
  parameter int SECTORS = 12,
  parameter int SEC_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sector_pulse,
  input  logic             index_pulse,
  output logic [SEC_W-1:0] sec_num,
  output logic [SEC_W-1:0] sec_next
);
  logic idx_pend;

  always_comb begin
    if (!sector_pulse)                          sec_next = sec_num;
    else if (idx_pend)                          sec_next = '0;
    else if (sec_num == SEC_W'(SECTORS - 1))    sec_next = '0;
    else                                        sec_next = sec_num + SEC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_num  <= '0;
      idx_pend <= 1'b0;
    end else begin
      sec_num  <= sec_next;
      idx_pend <= index_pulse | (idx_pend & ~sector_pulse);
    end
  end

  // R2: pulse after an index goes to sector 0
  assert_zero_after_index_R2: assert property (@(posedge clk) disable iff (rst)
    (sector_pulse && idx_pend) |=> (sec_num == '0));
  // R1: number only moves on a sector pulse
  assert_hold_without_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    !sector_pulse |=> $stable(sec_num));
endmodule

// File: rtl/secfmt_writer.sv
module secfmt_writer
  import secfmt_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int DATA_WORDS = 256,
  parameter int PRE_WORDS  = 15,
  parameter int SEC_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sector_pulse,
  input  logic [SEC_W-1:0]        sec_next,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [WORD_W-SEC_W-1:0] hdr_cyl,
  output logic                    tx_bit,
  output logic                    tx_en
);
  localparam int AW          = $clog2(DATA_WORDS);
  localparam int WW          = $clog2(WORD_W);
  localparam int HDR_IDX     = PRE_WORDS;
  localparam int DAT_IDX     = PRE_WORDS + 1;
  localparam int SUM_IDX     = DAT_IDX + DATA_WORDS;
  localparam int TOTAL_WORDS = SUM_IDX + 2;
  localparam int TOTAL_BITS  = TOTAL_WORDS * WORD_W;
  localparam int PW          = $clog2(TOTAL_BITS);

  wr_state_e         st;
  logic [AW-1:0]     wptr;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] hdr;
  logic [PW-1:0]     pos;
  logic [PW-1:0]     pos_n, wd, wn, rel;
  logic [WW-1:0]     bsel;
  logic [AW-1:0]     raddr;
  logic [WORD_W-1:0] q, cur_word, shifted;
  logic              acc;

  logic [WORD_W-1:0] mem [DATA_WORDS];

  assign wr_ready = (st == W_LOAD);
  assign acc      = wr_valid && (st == W_LOAD);
  assign pos_n    = pos + PW'(1);
  assign wd       = pos >> WW;
  assign wn       = pos_n >> WW;
  assign bsel     = pos[WW-1:0];
  assign rel      = wn - PW'(DAT_IDX);
  assign raddr    = rel[AW-1:0];

  // buffer: registered read, one word ahead of the word being sent
  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= wr_data;
    q <= mem[raddr];
  end

  always_comb begin
    if (wd < PW'(PRE_WORDS - 1))       cur_word = '0;
    else if (wd == PW'(PRE_WORDS - 1)) cur_word = WORD_W'(1);
    else if (wd == PW'(HDR_IDX))       cur_word = hdr;
    else if (wd < PW'(SUM_IDX))        cur_word = q;
    else if (wd == PW'(SUM_IDX))       cur_word = sum;
    else                               cur_word = '0;
    shifted = cur_word << bsel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= W_LOAD;
      wptr   <= '0;
      sum    <= '0;
      hdr    <= '0;
      pos    <= '0;
      tx_bit <= 1'b0;
      tx_en  <= 1'b0;
    end else begin
      tx_en  <= (st == W_SEND);
      tx_bit <= (st == W_SEND) && shifted[WORD_W-1];
      case (st)
        W_LOAD: if (wr_valid) begin
          sum  <= sum + wr_data;
          wptr <= wptr + AW'(1);
          if (wptr == AW'(DATA_WORDS - 1)) st <= W_ARMED;
        end
        W_ARMED: if (sector_pulse) begin
          st  <= W_SEND;
          pos <= '0;
          hdr <= {hdr_cyl, sec_next};
        end
        default: begin
          if (pos == PW'(TOTAL_BITS - 1)) begin
            st   <= W_LOAD;
            sum  <= '0;
            wptr <= '0;
          end else begin
            pos <= pos_n;
          end
        end
      endcase
    end
  end

  // R3: last accepted word closes the buffer
  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && wptr == AW'(DATA_WORDS - 1)) |=> !wr_ready);
  // R4: a stream only starts from a sector pulse
  assert_send_on_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(st == W_SEND) |-> $past(sector_pulse));
endmodule

// File: rtl/secfmt_reader.sv
module secfmt_reader
  import secfmt_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int DATA_WORDS = 256,
  parameter int SEC_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sector_pulse,
  input  logic [SEC_W-1:0]        sec_next,
  input  logic                    rd_enable,
  input  logic [WORD_W-SEC_W-1:0] exp_cyl,
  input  logic                    rx_bit,
  input  logic                    rx_valid,
  output logic [WORD_W-1:0]       rd_word,
  output logic                    rd_valid,
  output logic                    rd_done,
  output logic                    hdr_err,
  output logic                    sum_err
);
  localparam int AW = $clog2(DATA_WORDS);
  localparam int WW = $clog2(WORD_W);

  rd_state_e         st;
  logic [WORD_W-1:0] sh, exp_hdr, accum, word_in;
  logic [WW-1:0]     bcnt;
  logic [AW-1:0]     wcnt;
  logic              hdr_bad, last;

  assign word_in = {sh[WORD_W-2:0], rx_bit};
  assign last    = (bcnt == WW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= R_IDLE; sh <= '0; exp_hdr <= '0; accum <= '0;
      bcnt <= '0; wcnt <= '0; hdr_bad <= 1'b0;
      rd_word <= '0; rd_valid <= 1'b0; rd_done <= 1'b0;
      hdr_err <= 1'b0; sum_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      case (st)
        R_IDLE: if (sector_pulse && rd_enable) begin
          st      <= R_HUNT;
          exp_hdr <= {exp_cyl, sec_next};
        end
        R_HUNT: if (rx_valid && rx_bit) begin
          st   <= R_HDR;
          bcnt <= '0;
        end
        R_HDR: if (rx_valid) begin
          sh   <= word_in;
          bcnt <= bcnt + WW'(1);
          if (last) begin
            hdr_bad <= (word_in != exp_hdr);
            wcnt    <= '0;
            accum   <= '0;
            st      <= R_DATA;
          end
        end
        R_DATA: if (rx_valid) begin
          sh   <= word_in;
          bcnt <= bcnt + WW'(1);
          if (last) begin
            rd_word  <= word_in;
            rd_valid <= 1'b1;
            accum    <= accum + word_in;
            wcnt     <= wcnt + AW'(1);
            if (wcnt == AW'(DATA_WORDS - 1)) st <= R_SUM;
          end
        end
        default: if (rx_valid) begin
          sh   <= word_in;
          bcnt <= bcnt + WW'(1);
          if (last) begin
            rd_done <= 1'b1;
            hdr_err <= hdr_bad;
            sum_err <= (word_in != accum);
            st      <= R_IDLE;
          end
        end
      endcase
    end
  end

  // R7: a word is only delivered right after a valid bit
  assert_word_needs_bit_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rx_valid));
  // R8: completion follows a valid checksum bit
  assert_done_needs_bit_R8: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> $past(rx_valid && st == R_SUM));
endmodule

// File: rtl/sector_fmt.sv
module sector_fmt #(
  parameter int WORD_W     = 16,
  parameter int DATA_WORDS = 256,
  parameter int PRE_WORDS  = 15,
  parameter int SECTORS    = 12,
  parameter int SEC_W      = 4,
  localparam int CYL_W     = WORD_W - SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sector_pulse,
  input  logic              index_pulse,
  output logic [SEC_W-1:0]  sec_num,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CYL_W-1:0]  hdr_cyl,
  output logic              tx_bit,
  output logic              tx_en,
  input  logic              rd_enable,
  input  logic [CYL_W-1:0]  exp_cyl,
  input  logic              rx_bit,
  input  logic              rx_valid,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid,
  output logic              rd_done,
  output logic              hdr_err,
  output logic              sum_err
);
  logic [SEC_W-1:0] sec_next;

  secfmt_counter #(.SECTORS(SECTORS), .SEC_W(SEC_W)) i_counter (
    .clk, .rst, .sector_pulse, .index_pulse, .sec_num, .sec_next
  );

  secfmt_writer #(.WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS),
                  .PRE_WORDS(PRE_WORDS), .SEC_W(SEC_W)) i_writer (
    .clk, .rst, .sector_pulse, .sec_next, .wr_valid, .wr_ready,
    .wr_data, .hdr_cyl, .tx_bit, .tx_en
  );

  secfmt_reader #(.WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS),
                  .SEC_W(SEC_W)) i_reader (
    .clk, .rst, .sector_pulse, .sec_next, .rd_enable, .exp_cyl,
    .rx_bit, .rx_valid, .rd_word, .rd_valid, .rd_done, .hdr_err, .sum_err
  );
endmodule

// File: tb/test_sector_fmt.sv
`timescale 1ns/1ps
module test_sector_fmt;
  localparam int NW = 256;
  localparam int NS = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sp, idx, wr_valid, rd_enable, flip, force1;
  logic [15:0] wr_data;
  logic [11:0] hdr_cyl, exp_cyl;
  logic [3:0]  sec_num;
  logic wr_ready, tx_bit, tx_en, rd_valid, rd_done, hdr_err, sum_err;
  logic [15:0] rd_word;
  logic rx_bit, rx_valid;

  assign rx_bit   = force1 ? 1'b1 : (tx_bit ^ flip);
  assign rx_valid = tx_en & ~force1;

  sector_fmt i_sector_fmt (
    .clk, .rst, .sector_pulse(sp), .index_pulse(idx), .sec_num,
    .wr_valid, .wr_ready, .wr_data, .hdr_cyl, .tx_bit, .tx_en,
    .rd_enable, .exp_cyl, .rx_bit, .rx_valid, .rd_word, .rd_valid,
    .rd_done, .hdr_err, .sum_err
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_sec, m_wst, m_rst, m_n;
  bit m_idx, m_ready, m_txen, m_txbit, m_txtag6;
  bit m_rvalid, m_rdone, m_herr, m_serr, m_hbad;
  logic [15:0] m_sum, m_sh, m_hexp, m_acc, m_rword;
  logic [15:0] dq[$];
  bit txq[$];
  bit tagq[$];

  task automatic push_word(input logic [15:0] w, input bit tag6);
    for (int b = 15; b >= 0; b--) begin txq.push_back(w[b]); tagq.push_back(tag6); end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_sec = 0; m_idx = 0; m_wst = 0; m_sum = '0; dq.delete(); txq.delete(); tagq.delete();
      m_ready = 1; m_txen = 0; m_txbit = 0; m_rst = 0; m_n = 0;
      m_rvalid = 0; m_rdone = 0; m_herr = 0; m_serr = 0; m_hbad = 0;
    end else begin
      int s_new;
      bit go_load;
      s_new = m_sec;
      if (sp) s_new = m_idx ? 0 : ((m_sec == NS-1) ? 0 : m_sec + 1);
      m_idx = idx | (m_idx & !sp);
      m_sec = s_new;
      // writer
      go_load = 0;
      if (txq.size() > 0) begin
        m_txen = 1; m_txbit = txq.pop_front(); m_txtag6 = tagq.pop_front();
        if (txq.size() == 0) go_load = 1;
      end else begin
        m_txen = 0; m_txbit = 0;
      end
      case (m_wst)
        0: if (wr_valid) begin
          dq.push_back(wr_data); m_sum = m_sum + wr_data;
          if (dq.size() == NW) m_wst = 1;
        end
        1: if (sp) begin
          for (int i = 0; i < 239; i++) begin txq.push_back(0); tagq.push_back(0); end
          txq.push_back(1); tagq.push_back(0);
          push_word({hdr_cyl, 4'(s_new)}, 0);
          foreach (dq[i]) push_word(dq[i], 0);
          push_word(m_sum, 1);
          push_word(16'h0000, 0);
          dq.delete(); m_sum = '0; m_wst = 2;
        end
        default: ;
      endcase
      if (go_load) m_wst = 0;
      m_ready = (m_wst == 0);
      // reader
      m_rvalid = 0; m_rdone = 0;
      case (m_rst)
        0: if (sp && rd_enable) begin m_rst = 1; m_hexp = {exp_cyl, 4'(s_new)}; end
        1: if (rx_valid && rx_bit) begin m_rst = 2; m_n = 0; m_acc = '0; end
        default: if (rx_valid) begin
          m_sh = {m_sh[14:0], rx_bit}; m_n++;
          if (m_n == 16) m_hbad = (m_sh != m_hexp);
          else if (m_n % 16 == 0 && m_n <= 16 * (NW + 1)) begin
            m_rvalid = 1; m_rword = m_sh; m_acc = m_acc + m_sh;
          end else if (m_n == 16 * (NW + 2)) begin
            m_rdone = 1; m_herr = m_hbad; m_serr = (m_sh != m_acc); m_rst = 0;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(sec_num == 4'(m_sec), "R1/R2", "sec_num", sec_num, m_sec);
      check(wr_ready == m_ready, "R3", "wr_ready", wr_ready, m_ready);
      check(tx_en == m_txen, "R4", "tx_en", tx_en, m_txen);
      if (m_txen) check(tx_bit == m_txbit, m_txtag6 ? "R6" : "R5", "tx_bit", tx_bit, m_txbit);
      check(rd_valid == m_rvalid, "R7", "rd_valid", rd_valid, m_rvalid);
      if (m_rvalid) check(rd_word == m_rword, "R7", "rd_word", rd_word, m_rword);
      check(rd_done == m_rdone, "R8", "rd_done", rd_done, m_rdone);
      if (m_rdone) begin
        check(sum_err == m_serr, "R8", "sum_err", sum_err, m_serr);
        check(hdr_err == m_herr, "R9", "hdr_err", hdr_err, m_herr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulse_sector();
    sp = 1; tick(1); sp = 0; tick(1);
  endtask

  task automatic load(input int kind);
    for (int i = 0; i < NW; i++) begin
      wr_valid = 1;
      wr_data  = (kind == 0) ? 16'(i * 16'h0123 + 16'h005A) : 16'hFFFF;
      forever begin
        @(negedge clk);
        if (wr_ready) break;
      end
      @(posedge clk); #1;
    end
    wr_valid = 0;
    @(negedge clk);
    check(wr_ready == 1'b0, "R3", "ready after 256 words", wr_ready, 0);
    tick(1);
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int c = 0; c < 6000 && !got; c++) begin
      @(negedge clk);
      if (rd_done) got = 1;
    end
    check(got, "R8", "rd_done seen", got, 1);
    tick(3);
  endtask

  bit finished = 0;

  initial begin
    bit got;
    rst = 1; sp = 0; idx = 0; wr_valid = 0; wr_data = '0; rd_enable = 0;
    flip = 0; force1 = 0; hdr_cyl = 12'h2A5; exp_cyl = 12'h2A5;
    tick(4);
    @(negedge clk);
    check(sec_num == 0, "R1", "reset sec_num", sec_num, 0);
    check(wr_ready == 1, "R3", "reset wr_ready", wr_ready, 1);
    check(tx_en == 0, "R4", "reset tx_en", tx_en, 0);
    check(rd_valid == 0 && rd_done == 0, "R7", "reset read outputs", {rd_valid, rd_done}, 0);
    rst = 0; tick(2);

    // R1 wrap: 13 pulses from 0 gives 1
    for (int i = 0; i < 13; i++) begin pulse_sector(); tick(i % 3); end
    @(negedge clk);
    check(sec_num == 1, "R1", "after 13 pulses", sec_num, 1);
    tick(1);
    // R2: index resynchronises
    pulse_sector(); pulse_sector();
    idx = 1; tick(1); idx = 0; tick(2);
    pulse_sector();
    @(negedge clk);
    check(sec_num == 0, "R2", "pulse after index", sec_num, 0);
    tick(1);

    // Test A: clean loopback
    rd_enable = 1;
    load(0);
    pulse_sector();
    tick(1000);
    pulse_sector();            // R4: ignored by writer while sending
    wait_done(got);
    check(hdr_err == 0, "R9", "clean header", hdr_err, 0);
    check(sum_err == 0, "R6", "clean checksum", sum_err, 0);

    // Test B: wrapping sum, header mismatch
    exp_cyl = 12'h2A4;
    load(1);
    pulse_sector();
    wait_done(got);
    check(hdr_err == 1, "R9", "wrong cylinder", hdr_err, 1);
    check(sum_err == 0, "R6", "wrapped checksum", sum_err, 0);
    exp_cyl = 12'h2A5;

    // Test C: flipped data bit
    load(0);
    pulse_sector();
    tick(400);
    flip = 1; tick(1); flip = 0;
    wait_done(got);
    check(sum_err == 1, "R8", "corrupted data", sum_err, 1);
    check(hdr_err == 0, "R9", "header intact", hdr_err, 0);

    // Test D: R10 masked cycle during preamble
    load(1);
    pulse_sector();
    tick(50);
    force1 = 1; tick(1); force1 = 0;
    wait_done(got);
    check(hdr_err == 0, "R10", "masked 1 not sync", hdr_err, 0);
    check(sum_err == 0, "R10", "masked 1 no shift", sum_err, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule